// File: doc/BRIEF.md
# Memory-Mapped SPI User-Mode Bridge

This block lets a processor run a serial flash device by hand. Software owns each device's select line through a hold bit in that device's control register. It moves raw bytes by making 1- to 4-byte accesses to the device's window. Each window access becomes one SPI byte per data byte, with the least significant byte going first. The serial engine runs SPI mode 0.

Registers use a plain write strobe and a combinational read mux. Window accesses use a valid/ready request stream and a valid/ready response stream. A request is taken on a cycle where both `win_valid` and `win_ready` are high. `win_ready` then stays low until the response is accepted. `rsp_valid` and `rsp_rdata` stay steady until `rsp_ready` is seen high at a clock edge. Every access, including a discarded one, returns exactly one response.

Top module: `spi_window_bridge`

## Requirements
- R1: After reset, every `spi_cs_n` bit is 1. Every control register reads 0x0000_0004, with the hold bit set and mode 0. The configuration register reads 0.
- R2: Register word addresses are: configuration at 0, status at 1, and control for device i at 8+i. A control register keeps mode in [1:0], hold in [2] and an opcode byte in [23:16]; all other bits read 0. The configuration register keeps only bits [16+i], one per device; all other bits read 0.
- R3: `spi_cs_n[i]` equals the hold bit of control register i. It changes on the clock edge that completes the register write.
- R4: When device d is in mode 3 (user), a read with `win_len` = N-1 makes N SPI byte transfers, each sending 0x00. Received byte k lands in `rsp_rdata[8k+7:8k]`. All higher bytes are 0.
- R5: When device d is in user mode and write enable is set, a write with `win_len` = N-1 sends bytes 0 to N-1 of `win_wdata` in that order, one transfer each.
- R6: A write to a device whose configuration bit [16+d] is clear causes no SPI traffic. It returns a response with data 0.
- R7: A write to a device in mode 0, 1 or 2 causes no SPI traffic, even when write enable is set.
- R8: A read from a device in mode 0, 1 or 2 causes no SPI traffic. It returns 0xFFFF_FFFF.
- R9: The serial clock is low when idle. MOSI changes only while the clock is low. MISO is sampled on the rising edge. Bits within a byte go most significant first.
- R10: `win_ready` is low from when a request is accepted until its response is taken. An unaccepted response holds its data.
- R11: When NCS is below 5, control addresses for devices that do not exist read 0 and ignore writes. A window access to a device index at or above NCS behaves as in R7 and R8.
- R12: The status register at word 1 always reads 0x0000_0800. Writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| win_valid | input | 1 | Window request valid |
| win_ready | output | 1 | Window request ready |
| win_write | input | 1 | 1 = write access, 0 = read access |
| win_cs | input | 3 | Target device index |
| win_len | input | 2 | Access length in bytes minus one |
| win_wdata | input | 32 | Write data, byte 0 sent first |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_rdata | output | 32 | Read result (0 for writes) |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NCS | Active-low device selects |

## Verification
On every cycle, the assertions check several things. The select lines follow each control write on the next edge. The request side stays stalled while a response is pending. A pending response holds its data. The serial clock rests low between accesses. Rejected reads and rejected writes respond at once with all-ones and zero.

Only the bench scenarios can show that the byte order and bit order are right on the wire. They also show that the transfer count matches the access length and that received bytes are assembled in the right lanes. These checks come from sweeping every device, every length and every mode against a serial target model.

// File: rtl/spiwb_pkg.sv
package spiwb_pkg;
  typedef enum logic [1:0] {
    MODE_NREAD = 2'd0,
    MODE_FREAD = 2'd1,
    MODE_WRITE = 2'd2,
    MODE_USER  = 2'd3
  } spi_mode_e;

  typedef struct packed {
    logic [7:0] opcode;
    logic       hold;
    spi_mode_e  mode;
  } dev_ctrl_t;

  localparam int          MAX_DEV    = 5;
  localparam int          CS_W       = 3;
  localparam int          REG_AW     = 5;
  localparam logic [4:0]  ADDR_CFG   = 5'd0;
  localparam logic [4:0]  ADDR_STAT  = 5'd1;
  localparam int          ADDR_CTRL0 = 8;
  localparam int          WE_LSB     = 16;
  localparam logic [31:0] STAT_VALUE = 32'h0000_0800;
endpackage

// File: rtl/spiwb_regs.sv
module spiwb_regs
  import spiwb_pkg::*;
#(
  parameter int NCS = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wen,
  input  logic [REG_AW-1:0]         reg_addr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  output logic [NCS-1:0][1:0]       dev_mode,
  output logic [NCS-1:0]            dev_hold,
  output logic [NCS-1:0]            dev_we
);
  dev_ctrl_t ctrl_q [NCS];
  logic [NCS-1:0] we_q;

  for (genvar gi = 0; gi < NCS; gi++) begin : g_dev
    localparam logic [REG_AW-1:0] CA = REG_AW'(ADDR_CTRL0 + gi);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_q[gi] <= '{opcode: 8'h00, hold: 1'b1, mode: MODE_NREAD};
      end else if (reg_wen && reg_addr == CA) begin
        ctrl_q[gi] <= '{opcode: reg_wdata[23:16], hold: reg_wdata[2],
                        mode: spi_mode_e'(reg_wdata[1:0])};
      end
    end
    assign dev_mode[gi] = ctrl_q[gi].mode;
    assign dev_hold[gi] = ctrl_q[gi].hold;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) we_q <= '0;
    else if (reg_wen && reg_addr == ADDR_CFG) we_q <= reg_wdata[WE_LSB +: NCS];
  end
  assign dev_we = we_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_CFG) reg_rdata[WE_LSB +: NCS] = we_q;
    if (reg_addr == ADDR_STAT) reg_rdata = STAT_VALUE;
    for (int i = 0; i < NCS; i++) begin
      if (reg_addr == REG_AW'(ADDR_CTRL0 + i))
        reg_rdata = {8'h00, ctrl_q[i].opcode, 13'h0000, ctrl_q[i].hold, ctrl_q[i].mode};
    end
  end
endmodule

// File: rtl/spiwb_shifter.sv
module spiwb_shifter #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi
);
  localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF - 1);

  logic          busy_q;
  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      div_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      sclk    <= 1'b0;
      done    <= 1'b0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        sh_q   <= tx_byte;
        bit_q  <= '0;
        div_q  <= '0;
        sclk   <= 1'b0;
      end else if (busy_q) begin
        if (div_q == DIV_LAST) begin
          div_q <= '0;
          if (!sclk) begin
            sclk    <= 1'b1;
            rx_byte <= {rx_byte[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bit_q == 3'd7) begin
              busy_q <= 1'b0;
              done   <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              sh_q  <= {sh_q[6:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign mosi = sh_q[7];
endmodule

// File: rtl/spiwb_seq.sv
module spiwb_seq
  import spiwb_pkg::*;
#(
  parameter int NCS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 win_valid,
  output logic                 win_ready,
  input  logic                 win_write,
  input  logic [CS_W-1:0]      win_cs,
  input  logic [1:0]           win_len,
  input  logic [31:0]          win_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [31:0]          rsp_rdata,
  input  logic [NCS-1:0][1:0]  dev_mode,
  input  logic [NCS-1:0]       dev_we,
  output logic                 sh_start,
  output logic [7:0]           sh_tx,
  input  logic                 sh_done,
  input  logic [7:0]           sh_rx
);
  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_RESP} seq_state_e;

  seq_state_e  state_q;
  logic [1:0]  idx_q, len_q;
  logic [31:0] wd_q, rd_q;
  logic        wr_q;
  logic        sel_user, sel_we;
  logic [1:0]  nidx;

  always_comb begin
    sel_user = 1'b0;
    sel_we   = 1'b0;
    for (int i = 0; i < NCS; i++) begin
      if (win_cs == CS_W'(i)) begin
        sel_user = (dev_mode[i] == MODE_USER);
        sel_we   = dev_we[i];
      end
    end
  end

  assign nidx = idx_q + 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      len_q    <= '0;
      wd_q     <= '0;
      rd_q     <= '0;
      wr_q     <= 1'b0;
      sh_start <= 1'b0;
      sh_tx    <= '0;
    end else begin
      sh_start <= 1'b0;
      case (state_q)
        S_IDLE: if (win_valid) begin
          idx_q <= '0;
          len_q <= win_len;
          wd_q  <= win_wdata;
          wr_q  <= win_write;
          rd_q  <= '0;
          if (sel_user && (!win_write || sel_we)) begin
            state_q  <= S_SHIFT;
            sh_start <= 1'b1;
            sh_tx    <= win_write ? win_wdata[7:0] : 8'h00;
          end else begin
            state_q <= S_RESP;
            rd_q    <= win_write ? 32'h0 : 32'hFFFF_FFFF;
          end
        end
        S_SHIFT: if (sh_done) begin
          if (!wr_q) rd_q[{idx_q, 3'b000} +: 8] <= sh_rx;
          if (idx_q == len_q) begin
            state_q <= S_RESP;
          end else begin
            idx_q    <= nidx;
            sh_start <= 1'b1;
            sh_tx    <= wr_q ? wd_q[{nidx, 3'b000} +: 8] : 8'h00;
          end
        end
        S_RESP: if (rsp_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign win_ready = (state_q == S_IDLE);
  assign rsp_valid = (state_q == S_RESP);
  assign rsp_rdata = rd_q;
endmodule

// File: rtl/spi_window_bridge.sv
module spi_window_bridge
  import spiwb_pkg::*;
#(
  parameter int NCS  = 5,
  parameter int HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              win_valid,
  output logic              win_ready,
  input  logic              win_write,
  input  logic [2:0]        win_cs,
  input  logic [1:0]        win_len,
  input  logic [31:0]       win_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NCS-1:0]    spi_cs_n
);
  logic [NCS-1:0][1:0] mode_vec;
  logic [NCS-1:0]      hold_vec;
  logic [NCS-1:0]      we_vec;
  logic                sh_start, sh_done;
  logic [7:0]          sh_tx, sh_rx;

  spiwb_regs #(.NCS(NCS)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dev_mode(mode_vec), .dev_hold(hold_vec), .dev_we(we_vec)
  );

  spiwb_seq #(.NCS(NCS)) u_seq (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_ready(win_ready),
    .win_write(win_write), .win_cs(win_cs), .win_len(win_len),
    .win_wdata(win_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .dev_mode(mode_vec), .dev_we(we_vec),
    .sh_start(sh_start), .sh_tx(sh_tx), .sh_done(sh_done), .sh_rx(sh_rx)
  );

  spiwb_shifter #(.HALF(HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_tx),
    .miso(spi_miso), .done(sh_done), .rx_byte(sh_rx),
    .sclk(spi_sclk), .mosi(spi_mosi)
  );

  assign spi_cs_n = hold_vec;
endmodule

// File: rtl/spiwb_checker.sv
module spiwb_checker
  import spiwb_pkg::*;
#(
  parameter int NCS = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wen,
  input logic [4:0]          reg_addr,
  input logic [31:0]         reg_wdata,
  input logic                win_valid,
  input logic                win_ready,
  input logic                win_write,
  input logic [2:0]          win_cs,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [31:0]         rsp_rdata,
  input logic                spi_sclk,
  input logic [NCS-1:0]      spi_cs_n,
  input logic [NCS-1:0][1:0] cs_mode,
  input logic [NCS-1:0]      cs_we
);
  logic tgt_user, tgt_we;
  always_comb begin
    tgt_user = 1'b0;
    tgt_we   = 1'b0;
    for (int i = 0; i < NCS; i++) begin
      if (win_cs == 3'(i)) begin
        tgt_user = (cs_mode[i] == 2'd3);
        tgt_we   = cs_we[i];
      end
    end
  end

  for (genvar gi = 0; gi < NCS; gi++) begin : g_cs
    localparam logic [4:0] CA = 5'(ADDR_CTRL0 + gi);
    a_r3_select_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wen && reg_addr == CA) |=> (spi_cs_n[gi] == $past(reg_wdata[2])));
  end

  a_r10_stall_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !win_ready);

  a_r10_response_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  a_r9_clock_rests_low: assert property (@(posedge clk) disable iff (!rst_n)
    win_ready |-> !spi_sclk);

  a_r8_rejected_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_ready && !win_write && !tgt_user) |=> (rsp_valid && rsp_rdata == 32'hFFFF_FFFF));

  a_r6_blocked_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_ready && win_write && (!tgt_we || !tgt_user)) |=> (rsp_valid && rsp_rdata == 32'h0));
endmodule

bind spi_window_bridge spiwb_checker #(.NCS(NCS)) i_spiwb_checker (
  .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .win_valid(win_valid), .win_ready(win_ready),
  .win_write(win_write), .win_cs(win_cs), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .spi_sclk(spi_sclk),
  .spi_cs_n(spi_cs_n), .cs_mode(mode_vec), .cs_we(we_vec)
);

// File: tb/test_spi_window_bridge.sv
`timescale 1ns/1ps
module test_spi_window_bridge;
  localparam int NCS = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wen = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic win_valid = 1'b0, win_ready, win_write = 1'b0;
  logic [2:0] win_cs = '0;
  logic [1:0] win_len = '0;
  logic [31:0] win_wdata = '0;
  logic rsp_valid, rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic spi_sclk, spi_mosi, spi_miso;
  logic [NCS-1:0] spi_cs_n;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  spi_window_bridge #(.NCS(NCS), .HALF(2)) i_spi_window_bridge (.*);

  // serial target model
  logic [7:0] s_out, s_in;
  logic [2:0] s_bit = '0;
  int s_cnt = 0, s_gidx = 0;
  logic [7:0] s_log [8];
  logic [NCS-1:0] s_cs_log [8];

  function automatic logic [7:0] resp_byte(int g);
    return 8'(8'h5A ^ (g * 37));
  endfunction

  initial s_out = resp_byte(0);
  assign spi_miso = s_out[3'd7 - s_bit];

  always @(posedge spi_sclk) begin
    s_in = {s_in[6:0], spi_mosi};
    if (s_bit == 3'd7) begin
      if (s_cnt < 8) begin
        s_log[s_cnt] = s_in;
        s_cs_log[s_cnt] = spi_cs_n;
      end
      s_cnt = s_cnt + 1;
      s_gidx = s_gidx + 1;
      s_out = resp_byte(s_gidx);
      s_bit = '0;
    end else begin
      s_bit = s_bit + 3'd1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic win_acc(input logic wr, input logic [2:0] cs, input logic [1:0] len,
                         input logic [31:0] wd, output logic [31:0] rd);
    logic [31:0] first;
    s_cnt = 0;
    @(negedge clk);
    win_valid = 1'b1; win_write = wr; win_cs = cs; win_len = len; win_wdata = wd;
    @(negedge clk);
    win_valid = 1'b0;
    chk(win_ready == 1'b0, "R10 ready low after accept", 32'(win_ready), 32'h0);
    while (!rsp_valid) @(negedge clk);
    first = rsp_rdata;
    repeat (2) @(negedge clk);
    chk(rsp_valid && rsp_rdata == first, "R10 response held", rsp_rdata, first);
    rd = rsp_rdata;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(spi_sclk == 1'b0, "R9 clock low at rest", 32'(spi_sclk), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, exp;
    int g0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(spi_cs_n == '1, "R1 selects idle", 32'(spi_cs_n), 32'(3'b111));
    for (int i = 0; i < NCS; i++) begin
      reg_rd(5'(8 + i), d);
      chk(d == 32'h4, "R1 control reset", d, 32'h4);
    end
    reg_rd(5'd0, d);
    chk(d == 32'h0, "R1 config reset", d, 32'h0);
    reg_rd(5'd1, d);
    chk(d == 32'h800, "R12 status reset", d, 32'h800);
    reg_wr(5'd1, 32'hFFFF_FFFF);
    reg_rd(5'd1, d);
    chk(d == 32'h800, "R12 status write ignored", d, 32'h800);

    // R2 field layout
    reg_wr(5'd9, 32'hFFFF_FFFF);
    reg_rd(5'd9, d);
    chk(d == 32'h00FF_0007, "R2 control fields", d, 32'h00FF_0007);
    chk(spi_cs_n[1] == 1'b1, "R3 hold set deselects", 32'(spi_cs_n[1]), 32'h1);
    reg_wr(5'd0, 32'hFFFF_FFFF);
    reg_rd(5'd0, d);
    chk(d == 32'h0007_0000, "R2 config fields", d, 32'h0007_0000);

    // R11 absent device offsets
    for (int i = NCS; i < 5; i++) begin
      reg_wr(5'(8 + i), 32'h00AB_0003);
      reg_rd(5'(8 + i), d);
      chk(d == 32'h0, "R11 absent control reads zero", d, 32'h0);
    end

    // R3 select follows hold bit, one edge after the write
    for (int c = 0; c < NCS; c++) begin
      @(negedge clk);
      reg_wen = 1'b1; reg_addr = 5'(8 + c); reg_wdata = 32'h0003_0003;
      @(negedge clk);
      reg_wen = 1'b0;
      chk(spi_cs_n == 3'(~(3'b1 << c)), "R3 select low", 32'(spi_cs_n), 32'(~(3'b1 << c) & 3'b111));
      reg_wr(5'(8 + c), 32'h4);
      chk(spi_cs_n == '1, "R3 select released", 32'(spi_cs_n), 32'h7);
    end

    // sweep devices, lengths and modes
    for (int c = 0; c < NCS; c++) begin
      reg_wr(5'd0, 32'h0007_0000);
      reg_wr(5'(8 + c), 32'h0000_0003);
      for (int L = 0; L < 4; L++) begin
        // R4 user read
        g0 = s_gidx;
        exp = '0;
        for (int k = 0; k <= L; k++) exp[k*8 +: 8] = resp_byte(g0 + k);
        win_acc(1'b0, 3'(c), 2'(L), 32'h0, d);
        chk(d == exp, "R4 read data lanes", d, exp);
        chk(s_cnt == L + 1, "R4 read transfer count", 32'(s_cnt), 32'(L + 1));
        for (int k = 0; k <= L && k < 8; k++) begin
          chk(s_log[k] == 8'h00, "R4 read sends zeros", 32'(s_log[k]), 32'h0);
          chk(s_cs_log[k][c] == 1'b0, "R3 device selected during transfer", 32'(s_cs_log[k][c]), 32'h0);
        end
        // R5 user write, LSB first, MSB first on the wire (R9)
        exp = 32'h8C4E_2D71 + 32'(c) * 32'h0101_0101 + 32'(L) * 32'h1357_0000;
        win_acc(1'b1, 3'(c), 2'(L), exp, d);
        chk(d == 32'h0, "R5 write response zero", d, 32'h0);
        chk(s_cnt == L + 1, "R5 write transfer count", 32'(s_cnt), 32'(L + 1));
        for (int k = 0; k <= L && k < 8; k++)
          chk(s_log[k] == exp[k*8 +: 8], "R5 R9 write byte order", 32'(s_log[k]), 32'(exp[k*8 +: 8]));
      end
      // R6 write enable clear
      reg_wr(5'd0, 32'h0007_0000 & ~(32'h1 << (16 + c)));
      win_acc(1'b1, 3'(c), 2'd3, 32'hDEAD_BEEF, d);
      chk(s_cnt == 0, "R6 blocked write no traffic", 32'(s_cnt), 32'h0);
      chk(d == 32'h0, "R6 blocked write response", d, 32'h0);
      reg_wr(5'd0, 32'h0007_0000);
      // R7 R8 non-user modes
      for (int m = 0; m < 3; m++) begin
        reg_wr(5'(8 + c), 32'(m));
        win_acc(1'b0, 3'(c), 2'(m), 32'h0, d);
        chk(d == 32'hFFFF_FFFF, "R8 non-user read ones", d, 32'hFFFF_FFFF);
        chk(s_cnt == 0, "R8 non-user read no traffic", 32'(s_cnt), 32'h0);
        win_acc(1'b1, 3'(c), 2'd1, 32'h1234_5678, d);
        chk(s_cnt == 0, "R7 non-user write no traffic", 32'(s_cnt), 32'h0);
      end
      reg_wr(5'(8 + c), 32'h4);
    end

    // R11 absent device window
    win_acc(1'b0, 3'd3, 2'd2, 32'h0, d);
    chk(d == 32'hFFFF_FFFF, "R11 absent device read", d, 32'hFFFF_FFFF);
    chk(s_cnt == 0, "R11 absent device read no traffic", 32'(s_cnt), 32'h0);
    win_acc(1'b1, 3'd4, 2'd0, 32'hAA, d);
    chk(s_cnt == 0, "R11 absent device write no traffic", 32'(s_cnt), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule